// File: doc/BRIEF.md
# Multidrop Scan Address Selector

This block decides whether one scan bridge on a shared test backplane is the one being addressed. Many bridges see the same test clock, mode and data lines. Each bridge compares the value shifted into its 8-bit instruction register against a 7-bit slot number taken from static pins. The comparison happens only while the bridge is waiting for an address. The outcome is held in a small state machine until a return-to-wait opcode or a TAP reset. Reserved codes address every bridge at once, address a programmable multicast group, or ask every bridge to answer an interrogation.

The surrounding TAP controller supplies one-cycle Update-IR strobes, Shift-IR and Shift-DR levels, and a Test-Logic-Reset level. The instruction register supplies its parallel contents. The data path uses the `selected` flag to decide whether later instructions apply. It uses `query_resp` to return the slot number, and `tdo_en` to decide whether the bridge may drive the shared test data output.

Top module: `msel_addr_selector`

## Requirements
- R1: After rst_n is released, and before any instruction load, `selected`, `query_resp` and `tdo_en` are all 0 and the block is waiting for an address.
- R2: While waiting, an Update-IR strobe with ir_value[7] = 0 and ir_value[6:0] equal to a usable slot_id sets `selected` in the cycle after the strobe.
- R3: While waiting, a load that matches nothing makes the bridge unselected. Further loads, including its own slot address, leave `selected` and `query_resp` at 0 until it returns to waiting.
- R4: While waiting, the code 0x3B selects the bridge whatever its slot_id.
- R5: While waiting, a code 0x3C + g (g from 0 to 3) selects the bridge only when mcast_grp equals g. Otherwise the load counts as a mismatch.
- R6: While waiting, the code 0x3A sets `query_resp` and leaves `selected` at 0. The two flags are never high together.
- R7: An all-zero load never selects. A slot_id of 0, or one in 0x3A..0x3F, is not usable, so a load equal to it selects only through its reserved meaning.
- R8: The return-to-wait opcode 0x83, loaded in any state, clears both flags and resumes address matching. A high tap_reset does the same and takes priority over a same-cycle Update-IR strobe.
- R9: Once selected, Update-IR loads other than 0x83 keep `selected` at 1.
- R10: `tdo_en` is 1 exactly when `selected` is 1 and tap_shift_ir or tap_shift_dr is high, in the same cycle.
- R11: While waiting, a load with ir_value[7] = 1 other than 0x83 counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock domain clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| tap_reset | input | 1 | TAP is in Test-Logic-Reset |
| tap_update_ir | input | 1 | One-cycle strobe: TAP is in Update-IR |
| tap_shift_ir | input | 1 | TAP is in Shift-IR |
| tap_shift_dr | input | 1 | TAP is in Shift-DR |
| ir_value | input | 8 | Parallel contents of the instruction register |
| slot_id | input | 7 | Static slot address pins |
| mcast_grp | input | 2 | Multicast group number of this bridge |
| selected | output | 1 | Bridge is addressed; instructions apply |
| query_resp | output | 1 | Bridge answers an interrogation |
| tdo_en | output | 1 | Bridge may drive the shared test data output |

## Verification
The bench sweeps every 8-bit load against slot numbers at the edges of the reserved band, at 0 and at 0x7F, for each multicast group. A decoder that let a slot set inside 0x3A..0x3F win a direct match, or that ignored ir_value[7], would select on the wrong code. A group compare with the wrong offset would select one group early or late. After each load the bench reloads the bridge's own address and then sends the return-to-wait opcode. An unselected bridge that kept matching, a selected bridge that dropped out, or a wait return that failed shows up in the next trial. Directed steps check that tap_reset wins over a same-cycle strobe, and that `tdo_en` stays low while shifting when the bridge is not selected.

// File: rtl/msel_pkg.sv
package msel_pkg;

  typedef enum logic [1:0] {
    SEL_WAIT  = 2'd0,
    SEL_ON    = 2'd1,
    SEL_OFF   = 2'd2,
    SEL_QUERY = 2'd3
  } sel_state_e;

  typedef struct packed {
    logic goto_wait;
    logic query;
    logic hit;
  } ir_verdict_t;

endpackage

// File: rtl/msel_ir_match.sv
module msel_ir_match
  import msel_pkg::*;
#(
  parameter int unsigned IR_W       = 8,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned GRP_W      = 2,
  parameter int unsigned QUERY_CODE = 'h3A,
  parameter int unsigned BCAST_CODE = 'h3B,
  parameter int unsigned MCAST_BASE = 'h3C,
  parameter int unsigned GOTO_CODE  = 'h83
) (
  input  logic [IR_W-1:0]   ir_value,
  input  logic [ADDR_W-1:0] slot_id,
  input  logic [GRP_W-1:0]  mcast_grp,
  output ir_verdict_t       verdict
);

  localparam int unsigned NGRP = 1 << GRP_W;
  localparam logic [ADDR_W-1:0] QUERY_A = ADDR_W'(QUERY_CODE);
  localparam logic [ADDR_W-1:0] BCAST_A = ADDR_W'(BCAST_CODE);
  localparam logic [ADDR_W-1:0] RES_LO  = ADDR_W'(QUERY_CODE);
  localparam logic [ADDR_W-1:0] RES_HI  = ADDR_W'(MCAST_BASE + NGRP - 1);
  localparam logic [IR_W-1:0]   GOTO_V  = IR_W'(GOTO_CODE);

  // True when the bits above the address field are all zero.
  function automatic logic upper_clear(input logic [IR_W-1:0] v);
    return (v >> ADDR_W) == '0;
  endfunction

  // A slot can be matched directly only if it is nonzero and not reserved.
  function automatic logic slot_usable(input logic [ADDR_W-1:0] s);
    return (s != '0) && !((s >= RES_LO) && (s <= RES_HI));
  endfunction

  logic [ADDR_W-1:0] addr;
  logic              addr_ok;
  logic [NGRP-1:0]   mc_hit;
  logic              direct_hit;
  logic              bcast_hit;

  assign addr    = ir_value[ADDR_W-1:0];
  assign addr_ok = upper_clear(ir_value);

  for (genvar g = 0; g < NGRP; g++) begin : g_mcast
    localparam logic [ADDR_W-1:0] MC_A = ADDR_W'(MCAST_BASE + g);
    assign mc_hit[g] = (addr == MC_A) && (mcast_grp == GRP_W'(g));
  end

  assign direct_hit = (addr == slot_id) && slot_usable(slot_id);
  assign bcast_hit  = (addr == BCAST_A);

  always_comb begin
    verdict           = '0;
    verdict.goto_wait = (ir_value == GOTO_V);
    verdict.query     = addr_ok && (addr == QUERY_A);
    verdict.hit       = addr_ok && (bcast_hit || (|mc_hit) || direct_hit);
  end

endmodule

// File: rtl/msel_fsm.sv
module msel_fsm
  import msel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tap_reset,
  input  logic        tap_update_ir,
  input  ir_verdict_t verdict,
  output sel_state_e  state,
  output logic        st_wait
);

  sel_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (tap_reset) begin
      state_d = SEL_WAIT;
    end else if (tap_update_ir) begin
      if (verdict.goto_wait) begin
        state_d = SEL_WAIT;
      end else if (state_q == SEL_WAIT) begin
        if (verdict.query)    state_d = SEL_QUERY;
        else if (verdict.hit) state_d = SEL_ON;
        else                  state_d = SEL_OFF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEL_WAIT;
    else        state_q <= state_d;
  end

  assign state   = state_q;
  assign st_wait = (state_q == SEL_WAIT);

endmodule

// File: rtl/msel_tdo_gate.sv
module msel_tdo_gate (
  input  logic selected,
  input  logic shift_ir,
  input  logic shift_dr,
  output logic tdo_en
);

  assign tdo_en = selected && (shift_ir || shift_dr);

endmodule

// File: rtl/msel_addr_selector.sv
module msel_addr_selector
  import msel_pkg::*;
#(
  parameter int unsigned IR_W       = 8,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned GRP_W      = 2,
  parameter int unsigned QUERY_CODE = 'h3A,
  parameter int unsigned BCAST_CODE = 'h3B,
  parameter int unsigned MCAST_BASE = 'h3C,
  parameter int unsigned GOTO_CODE  = 'h83
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tap_reset,
  input  logic              tap_update_ir,
  input  logic              tap_shift_ir,
  input  logic              tap_shift_dr,
  input  logic [IR_W-1:0]   ir_value,
  input  logic [ADDR_W-1:0] slot_id,
  input  logic [GRP_W-1:0]  mcast_grp,
  output logic              selected,
  output logic              query_resp,
  output logic              tdo_en
);

  ir_verdict_t verdict;
  sel_state_e  state;
  logic        st_wait;

  msel_ir_match #(
    .IR_W(IR_W), .ADDR_W(ADDR_W), .GRP_W(GRP_W),
    .QUERY_CODE(QUERY_CODE), .BCAST_CODE(BCAST_CODE),
    .MCAST_BASE(MCAST_BASE), .GOTO_CODE(GOTO_CODE)
  ) u_match (
    .ir_value (ir_value),
    .slot_id  (slot_id),
    .mcast_grp(mcast_grp),
    .verdict  (verdict)
  );

  msel_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tap_reset    (tap_reset),
    .tap_update_ir(tap_update_ir),
    .verdict      (verdict),
    .state        (state),
    .st_wait      (st_wait)
  );

  assign selected   = (state == SEL_ON);
  assign query_resp = (state == SEL_QUERY);

  msel_tdo_gate u_gate (
    .selected(selected),
    .shift_ir(tap_shift_ir),
    .shift_dr(tap_shift_dr),
    .tdo_en  (tdo_en)
  );

endmodule

// File: rtl/msel_addr_selector_chk.sv
module msel_addr_selector_chk #(
  parameter int unsigned IR_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tap_reset,
  input logic            tap_update_ir,
  input logic            tap_shift_ir,
  input logic            tap_shift_dr,
  input logic [IR_W-1:0] ir_value,
  input logic            selected,
  input logic            query_resp,
  input logic            tdo_en,
  input logic            st_wait
);

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(selected && query_resp));

  p_tdo_needs_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tdo_en |-> (selected && (tap_shift_ir || tap_shift_dr)));

  p_goto_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_update_ir && ir_value == IR_W'('h83)) |=> (!selected && !query_resp && st_wait));

  p_tlr_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tap_reset |=> (st_wait && !selected && !query_resp));

  p_sel_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (selected && !tap_reset && !(tap_update_ir && ir_value == IR_W'('h83))) |=> selected);

  p_zero_never_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_update_ir && ir_value == '0) |=> !selected || $past(selected));

  p_bcast_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && tap_update_ir && !tap_reset && ir_value == IR_W'('h3B)) |=> selected);

endmodule

bind msel_addr_selector msel_addr_selector_chk #(.IR_W(IR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tap_reset    (tap_reset),
  .tap_update_ir(tap_update_ir),
  .tap_shift_ir (tap_shift_ir),
  .tap_shift_dr (tap_shift_dr),
  .ir_value     (ir_value),
  .selected     (selected),
  .query_resp   (query_resp),
  .tdo_en       (tdo_en),
  .st_wait      (st_wait)
);

// File: tb/msel_addr_selector_tb.sv
module msel_addr_selector_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tap_reset = 1'b0;
  logic       tap_update_ir = 1'b0;
  logic       tap_shift_ir = 1'b0;
  logic       tap_shift_dr = 1'b0;
  logic [7:0] ir_value = '0;
  logic [6:0] slot_id = '0;
  logic [1:0] mcast_grp = '0;
  logic       selected, query_resp, tdo_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msel_addr_selector dut_i (
    .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset),
    .tap_update_ir(tap_update_ir), .tap_shift_ir(tap_shift_ir),
    .tap_shift_dr(tap_shift_dr), .ir_value(ir_value), .slot_id(slot_id),
    .mcast_grp(mcast_grp), .selected(selected), .query_resp(query_resp),
    .tdo_en(tdo_en)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // Load one IR value: strobe high across exactly one rising edge.
  task automatic load(input logic [7:0] v);
    @(negedge clk);
    ir_value      = v;
    tap_update_ir = 1'b1;
    @(negedge clk);
    tap_update_ir = 1'b0;
  endtask

  // Independent model of the selection decision from the requirements.
  function automatic bit want_sel(input int ir, input int slot, input int grp);
    if (ir == 59) return 1'b1;
    if (ir >= 60 && ir <= 63) return (ir - 60) == grp;
    if (ir > 127) return 1'b0;
    if (slot == 0 || (slot >= 58 && slot <= 63)) return 1'b0;
    return ir == slot;
  endfunction

  function automatic string tag_for(input int ir, input int slot);
    if (ir == 59) return "R4";
    if (ir >= 60 && ir <= 63) return "R5";
    if (ir == 58) return "R6";
    if (ir > 127) return "R11";
    if (ir == 0 || slot == 0 || (slot >= 58 && slot <= 63)) return "R7";
    if (ir == slot) return "R2";
    return "R3";
  endfunction

  initial begin
    int slots[9] = '{0, 1, 2, 57, 58, 59, 63, 64, 127};
    #1;
    // R1: reset state
    check("R1", "selected in reset", selected, 1'b0);
    check("R1", "query_resp in reset", query_resp, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tap_shift_dr = 1'b1;
    #1;
    check("R1", "tdo_en after reset", tdo_en, 1'b0);
    check("R1", "selected after reset", selected, 1'b0);
    tap_shift_dr = 1'b0;

    // Sweep: slots x groups x every 8-bit load
    foreach (slots[si]) begin
      for (int g = 0; g < 4; g++) begin
        for (int ir = 0; ir < 256; ir++) begin
          bit es, eq;
          string t;
          if (ir == 131) continue;
          @(negedge clk);
          slot_id   = slots[si][6:0];
          mcast_grp = g[1:0];
          es = want_sel(ir, slots[si], g);
          eq = (ir == 58);
          t  = tag_for(ir, slots[si]);
          load(ir[7:0]);
          check(t, "selected after first load", selected, es);
          check("R6", "query_resp after first load", query_resp, eq);
          tap_shift_dr = 1'b1;
          #1;
          check("R10", "tdo_en during shift-DR", tdo_en, es);
          tap_shift_dr = 1'b0;
          // Second load of own address: state must not move (R3, R9)
          load({1'b0, slots[si][6:0]});
          check(es ? "R9" : "R3", "selected after reload", selected, es);
          check("R3", "query_resp after reload", query_resp, eq);
          load(8'h83);
          check("R8", "selected after return-to-wait", selected, 1'b0);
          check("R8", "query_resp after return-to-wait", query_resp, 1'b0);
        end
      end
    end

    // Directed: TAP reset clears a selected bridge (R8)
    @(negedge clk);
    slot_id = 7'd5; mcast_grp = 2'd0;
    load(8'h05);
    check("R2", "direct select slot 5", selected, 1'b1);
    tap_shift_ir = 1'b1;
    #1;
    check("R10", "tdo_en during shift-IR", tdo_en, 1'b1);
    tap_shift_ir = 1'b0;
    @(negedge clk);
    tap_reset = 1'b1;
    @(negedge clk);
    tap_reset = 1'b0;
    check("R8", "selected after tap_reset", selected, 1'b0);

    // tap_reset wins over a same-cycle strobe (R8)
    @(negedge clk);
    ir_value = 8'h07; tap_update_ir = 1'b1; tap_reset = 1'b1;
    @(negedge clk);
    tap_update_ir = 1'b0; tap_reset = 1'b0;
    check("R8", "mismatch masked by tap_reset", selected, 1'b0);
    load(8'h05);
    check("R8", "still waiting after masked load", selected, 1'b1);

    // Unselected bridge keeps tdo_en low while shifting (R10)
    load(8'h83);
    load(8'h06);
    tap_shift_ir = 1'b1; tap_shift_dr = 1'b1;
    #1;
    check("R10", "tdo_en when unselected", tdo_en, 1'b0);
    tap_shift_ir = 1'b0; tap_shift_dr = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule